// File: doc/BRIEF.md
# Flash Command Sequence Decoder with Unlock Bypass

This block sits between a synchronous host write bus and the embedded program/erase engine of a flash array. The host writes one byte per cycle, qualified by a write strobe. The decoder recognises the multi-cycle command sequences in those writes. It hands the engine a one-cycle request: either a program request carrying the target address and data byte, or a chip-erase request. A malformed sequence in normal mode drops the decoder back to read-array mode without issuing anything.

An unlock-bypass mode is available for bulk programming. After it is entered, each byte needs only two writes, a program command followed by the address/data cycle. In this mode every other write is ignored, except the two-cycle exit pair. While the engine reports busy, writes are not decoded at all. A hardware reset always returns the decoder to read-array mode.

States, each named in the RTL: ST_READ (read array, idle), ST_UNL1 (first unlock seen), ST_UNL2 (both unlocks seen, command expected), ST_PGM_DATA (program address/data expected), ST_ERS_SETUP (erase setup seen), ST_ERS_UNL1 and ST_ERS_UNL2 (second unlock pair in progress), ST_BYP_IDLE (bypass, command expected), ST_BYP_PGM (bypass, address/data expected), ST_BYP_EXIT (bypass, first exit byte seen).

Transitions, all taken only on a decoded write (strobe high, engine not busy):

| From | Write | To |
|---|---|---|
| READ | AAh at 555h | UNL1 |
| READ | any other write | READ |
| UNL1 | 55h at 2AAh | UNL2 |
| UNL1 | any other write | READ |
| UNL2 | A0h | PGM_DATA |
| UNL2 | 80h | ERS_SETUP |
| UNL2 | 20h | BYP_IDLE |
| UNL2 | any other write | READ |
| PGM_DATA | any write (issues program) | READ |
| ERS_SETUP | AAh at 555h | ERS_UNL1 |
| ERS_SETUP | any other write | READ |
| ERS_UNL1 | 55h at 2AAh | ERS_UNL2 |
| ERS_UNL1 | any other write | READ |
| ERS_UNL2 | 10h (issues chip erase) | READ |
| ERS_UNL2 | any other write | READ |
| BYP_IDLE | A0h | BYP_PGM |
| BYP_IDLE | 90h | BYP_EXIT |
| BYP_IDLE | any other write | BYP_IDLE |
| BYP_PGM | any write (issues program) | BYP_IDLE |
| BYP_EXIT | 00h | READ |
| BYP_EXIT | any other write | BYP_IDLE |

Top module: `flash_cmd_decoder`

## Requirements
- R1: While reset is low, and at the first sample after it is released, prog_req and erase_req are 0 and bypass_active is 0.
- R2: Four writes issue a standard program: AAh at an address whose low 11 bits are 555h, then 55h at low bits 2AAh, then A0h at any address, then the target address and data. They produce exactly one program request. Upper address bits above bit 10 are ignored in the unlock compares. The request carries the fourth write's address and data and is seen in the cycle after the clock edge that samples that write.
- R3: The six-write sequence AAh/555h, 55h/2AAh, 80h, AAh/555h, 55h/2AAh, 10h issues exactly one chip-erase request in the cycle after the sixth write.
- R4: The writes AAh/555h, 55h/2AAh, 20h put the decoder in unlock-bypass mode, and bypass_active reads 1 from the cycle after the third write.
- R5: In bypass mode, A0h at any address followed by an address/data write issues one program request with that address and data. The sequence can be repeated with no unlock writes, and the decoder stays in bypass mode.
- R6: In bypass mode, any write that is neither A0h nor 90h in the command position is ignored. Unlock bytes, erase commands and F0h are included. No request is issued and bypass_active stays 1.
- R7: Bypass mode is left only by 90h followed by 00h, at any addresses. If 90h is followed by any other byte, the decoder returns to bypass command-expected and stays in bypass mode.
- R8: In normal mode, a write that does not match the next expected cycle returns the decoder to read-array mode. A later A0h plus address/data issues nothing without a fresh unlock, and a fresh full sequence then works.
- R9: A write with eng_busy high is not decoded. It neither advances nor resets the sequence and issues no request.
- R10: A hardware reset in bypass mode clears bypass_active, and a following A0h plus address/data issues nothing.
- R11: prog_req and erase_req are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | DATA_W | Host write data (command byte in low 8 bits) |
| eng_busy | input | 1 | Embedded engine running; writes are not decoded |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Program target address, valid with prog_req |
| prog_data | output | DATA_W | Program data, valid with prog_req |
| erase_req | output | 1 | One-cycle chip-erase request |
| bypass_active | output | 1 | Decoder is in unlock-bypass mode |

## Verification
The bench targets the bypass corners. Unlock and erase bytes written inside bypass must be swallowed; a decoder that fell back to normal decoding would leave bypass or issue an erase. An aborted exit (90h then something other than 00h) must keep bypass mode, where a wrong design would drop to read mode and ignore the next program. Broken normal sequences are followed by a bare A0h and data to catch a decoder that keeps stale progress and issues a spurious program. A busy write placed mid-sequence must leave the sequence intact: a design that decoded it would abort, and one that reset on it would lose the program that follows.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PGM_DATA,
        ST_ERS_SETUP,
        ST_ERS_UNL1,
        ST_ERS_UNL2,
        ST_BYP_IDLE,
        ST_BYP_PGM,
        ST_BYP_EXIT
    } fcd_state_e;

    localparam logic [7:0] CMD_UNLOCK_A    = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B    = 8'h55;
    localparam logic [7:0] CMD_PROGRAM     = 8'hA0;
    localparam logic [7:0] CMD_ERASE_SETUP = 8'h80;
    localparam logic [7:0] CMD_CHIP_ERASE  = 8'h10;
    localparam logic [7:0] CMD_BYPASS      = 8'h20;
    localparam logic [7:0] CMD_BYP_EXIT_A  = 8'h90;
    localparam logic [7:0] CMD_BYP_EXIT_B  = 8'h00;

    localparam int UNLOCK_W = 11;
    localparam logic [UNLOCK_W-1:0] ADDR_UNL1 = 11'h555;
    localparam logic [UNLOCK_W-1:0] ADDR_UNL2 = 11'h2AA;

    typedef struct packed {
        logic unl1;
        logic unl2;
        logic pgm;
        logic setup;
        logic erase;
        logic byp_enter;
        logic exit_a;
        logic exit_b;
    } fcd_cls_t;

endpackage

// File: rtl/fcd_cycle_class.sv
module fcd_cycle_class
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output fcd_cls_t          cls
);
    localparam int CMD_W = 8;

    logic [UNLOCK_W-1:0] addr_lo;
    logic [CMD_W-1:0]    cmd;

    assign addr_lo = addr[UNLOCK_W-1:0];
    assign cmd     = data[CMD_W-1:0];

    always_comb begin
        cls.unl1      = (addr_lo == ADDR_UNL1) && (cmd == CMD_UNLOCK_A);
        cls.unl2      = (addr_lo == ADDR_UNL2) && (cmd == CMD_UNLOCK_B);
        cls.pgm       = (cmd == CMD_PROGRAM);
        cls.setup     = (cmd == CMD_ERASE_SETUP);
        cls.erase     = (cmd == CMD_CHIP_ERASE);
        cls.byp_enter = (cmd == CMD_BYPASS);
        cls.exit_a    = (cmd == CMD_BYP_EXIT_A);
        cls.exit_b    = (cmd == CMD_BYP_EXIT_B);
    end

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import fcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       busy,
    input  fcd_cls_t   cls,
    output fcd_state_e state,
    output logic       fire_prog,
    output logic       fire_erase,
    output logic       in_bypass
);
    fcd_state_e state_q;
    fcd_state_e state_d;
    logic       act;

    assign act   = wr_en && !busy;
    assign state = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READ;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (act) begin
            unique case (state_q)
                ST_READ:      if (cls.unl1) state_d = ST_UNL1;
                ST_UNL1:      state_d = cls.unl2 ? ST_UNL2 : ST_READ;
                ST_UNL2: begin
                    if (cls.pgm)            state_d = ST_PGM_DATA;
                    else if (cls.setup)     state_d = ST_ERS_SETUP;
                    else if (cls.byp_enter) state_d = ST_BYP_IDLE;
                    else                    state_d = ST_READ;
                end
                ST_PGM_DATA:  state_d = ST_READ;
                ST_ERS_SETUP: state_d = cls.unl1 ? ST_ERS_UNL1 : ST_READ;
                ST_ERS_UNL1:  state_d = cls.unl2 ? ST_ERS_UNL2 : ST_READ;
                ST_ERS_UNL2:  state_d = ST_READ;
                ST_BYP_IDLE: begin
                    if (cls.pgm)         state_d = ST_BYP_PGM;
                    else if (cls.exit_a) state_d = ST_BYP_EXIT;
                    else                 state_d = ST_BYP_IDLE;
                end
                ST_BYP_PGM:   state_d = ST_BYP_IDLE;
                ST_BYP_EXIT:  state_d = cls.exit_b ? ST_READ : ST_BYP_IDLE;
                default:      state_d = ST_READ;
            endcase
        end
    end

    always_comb begin
        fire_prog  = 1'b0;
        fire_erase = 1'b0;
        in_bypass  = 1'b0;
        unique case (state_q)
            ST_PGM_DATA: fire_prog  = act;
            ST_ERS_UNL2: fire_erase = act && cls.erase;
            ST_BYP_IDLE: in_bypass  = 1'b1;
            ST_BYP_PGM: begin
                in_bypass = 1'b1;
                fire_prog = act;
            end
            ST_BYP_EXIT: in_bypass  = 1'b1;
            default: begin
                fire_prog  = 1'b0;
                fire_erase = 1'b0;
                in_bypass  = 1'b0;
            end
        endcase
    end

    AST_BUSY_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || !wr_en) |=> $stable(state_q)); // R9

    AST_BYP_LEAVE_VIA_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_bypass) && !in_bypass) |-> ($past(state_q) == ST_BYP_EXIT)); // R7

    AST_BYP_ONE_HOT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fire_prog, fire_erase})); // R11

endmodule

// File: rtl/fcd_req_reg.sv
module fcd_req_reg #(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_prog,
    input  logic              fire_erase,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [DATA_W-1:0] cap_data,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_req
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_req  <= 1'b0;
            erase_req <= 1'b0;
            prog_addr <= '0;
            prog_data <= '0;
        end else begin
            prog_req  <= fire_prog;
            erase_req <= fire_erase;
            if (fire_prog) begin
                prog_addr <= cap_addr;
                prog_data <= cap_data;
            end
        end
    end

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_req && erase_req)); // R11

    AST_PROG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req); // R11

    AST_ERASE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req); // R11

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              eng_busy,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_req,
    output logic              bypass_active
);
    fcd_cls_t   cls;
    fcd_state_e state;
    logic       fire_prog;
    logic       fire_erase;
    logic       in_bypass;

    fcd_cycle_class #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_class (
        .addr (wr_addr),
        .data (wr_data),
        .cls  (cls)
    );

    fcd_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .busy       (eng_busy),
        .cls        (cls),
        .state      (state),
        .fire_prog  (fire_prog),
        .fire_erase (fire_erase),
        .in_bypass  (in_bypass)
    );

    fcd_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_prog  (fire_prog),
        .fire_erase (fire_erase),
        .cap_addr   (wr_addr),
        .cap_data   (wr_data),
        .prog_req   (prog_req),
        .prog_addr  (prog_addr),
        .prog_data  (prog_data),
        .erase_req  (erase_req)
    );

    assign bypass_active = in_bypass;

    AST_ERASE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> ($past(wr_en) && ($past(wr_data[7:0]) == CMD_CHIP_ERASE))); // R3

    AST_NO_REQ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |=> (!prog_req && !erase_req)); // R9

    AST_REQ_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req || erase_req) |-> $past(wr_en)); // R2

    AST_BYP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bypass_active) |-> ($past(state) == ST_UNL2)); // R4

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
    localparam int  ADDR_W   = 21;
    localparam int  DATA_W   = 8;
    localparam time CLK_PER  = 10ns;
    localparam int  WATCHDOG = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              eng_busy = 1'b0;
    logic              prog_req;
    logic [ADDR_W-1:0] prog_addr;
    logic [DATA_W-1:0] prog_data;
    logic              erase_req;
    logic              bypass_active;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        bit                is_erase;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        string             tag;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PER/2) clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .eng_busy      (eng_busy),
        .prog_req      (prog_req),
        .prog_addr     (prog_addr),
        .prog_data     (prog_data),
        .erase_req     (erase_req),
        .bypass_active (bypass_active)
    );

    // Monitor: pops the scoreboard whenever a request appears (R11 checked too)
    always @(negedge clk) begin
        if (rst_n && (prog_req || erase_req)) begin
            n_cmp++;
            if (prog_req && erase_req) begin
                n_bad++;
                $display("FAIL R11: both requests high, actual=11 expected=one");
            end else if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected request: actual prog=%0b erase=%0b addr=%h data=%h expected none",
                         prog_req, erase_req, prog_addr, prog_data);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.is_erase != erase_req ||
                    (!e.is_erase && (prog_addr != e.addr || prog_data != e.data))) begin
                    n_bad++;
                    $display("FAIL %s: actual erase=%0b addr=%h data=%h expected erase=%0b addr=%h data=%h",
                             e.tag, erase_req, prog_addr, prog_data, e.is_erase, e.addr, e.data);
                end
            end
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic push_prog(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input string tag);
        exp_t e;
        e.is_erase = 1'b0;
        e.addr = a;
        e.data = d;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic push_erase(input string tag);
        exp_t e;
        e.is_erase = 1'b1;
        e.addr = '0;
        e.data = '0;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic unlock();
        wr(21'h000555, 8'hAA);
        wr(21'h0002AA, 8'h55);
    endtask

    task automatic drain(input string tag);
        repeat (3) @(negedge clk);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL %s: pending expected requests actual=%0d expected=0", tag, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic chk(input logic act, input logic expv, input string what);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual=%0b expected=%0b", what, act, expv);
        end
    endtask

    task automatic hw_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(prog_req, 1'b0, "R1 prog_req in reset");
        chk(bypass_active, 1'b0, "R1 bypass in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(prog_req, 1'b0, "R1 prog_req after reset");
        chk(erase_req, 1'b0, "R1 erase_req after reset");
        chk(bypass_active, 1'b0, "R1 bypass after reset");

        // R2 standard program, then one with upper address bits set on unlocks
        unlock();
        wr(21'h000000, 8'hA0);
        push_prog(21'h12345, 8'h5A, "R2");
        wr(21'h12345, 8'h5A);
        drain("R2");
        wr(21'h1AD555, 8'hAA);
        wr(21'h0F02AA, 8'h55);
        wr(21'h1FFFFF, 8'hA0);
        push_prog(21'h1FFFFE, 8'hC3, "R2 upper bits");
        wr(21'h1FFFFE, 8'hC3);
        drain("R2 upper bits");

        // R3 chip erase
        unlock();
        wr(21'h000555, 8'h80);
        unlock();
        push_erase("R3");
        wr(21'h000555, 8'h10);
        drain("R3");

        // R8 broken sequences
        wr(21'h000555, 8'hAA);
        wr(21'h0002AB, 8'h55);
        wr(21'h000000, 8'hA0);
        wr(21'h000100, 8'h11);
        drain("R8 bad unlock");
        unlock();
        wr(21'h000555, 8'h80);
        unlock();
        wr(21'h000555, 8'h30);
        wr(21'h000000, 8'hA0);
        wr(21'h000101, 8'h22);
        drain("R8 bad erase cmd");
        unlock();
        wr(21'h000000, 8'h77);
        wr(21'h000102, 8'h33);
        drain("R8 bad command");
        unlock();
        wr(21'h000000, 8'hA0);
        push_prog(21'h000103, 8'h44, "R8 recovery");
        wr(21'h000103, 8'h44);
        drain("R8 recovery");

        // R4 enter bypass
        unlock();
        wr(21'h000555, 8'h20);
        chk(bypass_active, 1'b1, "R4 bypass entered");

        // R5 repeated bypass programs
        wr(21'h000000, 8'hA0);
        push_prog(21'h0A000, 8'h01, "R5 first");
        wr(21'h0A000, 8'h01);
        wr(21'h1234A, 8'hA0);
        push_prog(21'h0A001, 8'hFE, "R5 second");
        wr(21'h0A001, 8'hFE);
        drain("R5");
        chk(bypass_active, 1'b1, "R5 stays bypass");

        // R6 ignored writes in bypass
        unlock();
        wr(21'h000555, 8'h80);
        unlock();
        wr(21'h000555, 8'h10);
        wr(21'h000000, 8'hF0);
        drain("R6 ignored");
        chk(bypass_active, 1'b1, "R6 still bypass");
        wr(21'h000000, 8'hA0);
        push_prog(21'h0B000, 8'h66, "R6 program after ignored");
        wr(21'h0B000, 8'h66);
        drain("R6 program after ignored");

        // R7 aborted exit, then real exit
        wr(21'h000000, 8'h90);
        wr(21'h000000, 8'h33);
        chk(bypass_active, 1'b1, "R7 aborted exit keeps bypass");
        wr(21'h000000, 8'hA0);
        push_prog(21'h0C000, 8'h77, "R7 program after abort");
        wr(21'h0C000, 8'h77);
        drain("R7 program after abort");
        wr(21'h1ABCDE, 8'h90);
        wr(21'h054321, 8'h00);
        chk(bypass_active, 1'b0, "R7 exit");
        wr(21'h000000, 8'hA0);
        wr(21'h0C001, 8'h88);
        drain("R7 no program after exit");

        // R9 busy writes ignored
        eng_busy = 1'b1;
        unlock();
        wr(21'h000000, 8'hA0);
        wr(21'h0D000, 8'h99);
        eng_busy = 1'b0;
        drain("R9 busy full sequence");
        wr(21'h000555, 8'hAA);
        eng_busy = 1'b1;
        wr(21'h000000, 8'h12);
        eng_busy = 1'b0;
        wr(21'h0002AA, 8'h55);
        wr(21'h000000, 8'hA0);
        push_prog(21'h0D001, 8'hAB, "R9 busy mid-sequence");
        wr(21'h0D001, 8'hAB);
        drain("R9 busy mid-sequence");

        // R10 hardware reset clears bypass
        unlock();
        wr(21'h000555, 8'h20);
        chk(bypass_active, 1'b1, "R10 bypass before reset");
        hw_reset();
        @(negedge clk);
        chk(bypass_active, 1'b0, "R10 bypass cleared");
        wr(21'h000000, 8'hA0);
        wr(21'h0E000, 8'hCD);
        drain("R10 no program after reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule